// File: doc/BRIEF.md
# Packed Media Integer ALU

This block is a SIMD-within-a-register integer unit for audio and video inner loops. A single 64-bit word is treated as a set of equal-width lanes (eight 8-bit, four 16-bit, two 32-bit or one 64-bit). Every lane applies the same operation to its pair of source lanes: a rounding average, an absolute difference, an absolute difference added into an accumulator lane, a minimum or a maximum. A signed flag picks the interpretation of the lanes, and a saturate flag makes the accumulate clamp instead of wrap.

Operands arrive with a valid/ready handshake and are computed combinationally into one registered output stage. That stage is a two-state machine: `ST_EMPTY` (no result held) and `ST_FULL` (a result is held until the consumer takes it). Its transitions are `ACCEPT` (EMPTY to FULL on an accepted operand), `REFILL` (FULL to FULL when the held result leaves and a new operand enters in the same cycle), `DRAIN` (FULL to EMPTY when the result leaves and nothing enters) and `STALL` (FULL to FULL while the consumer is not ready). For min and max on the single 64-bit lane, a record flag produces a condition field from the comparison of the two inputs rather than from the selected value.

Top module: `pm_media_alu`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Opcode 3'd0 (average) gives, per lane, (a + b + 1) >> 1 computed without overflow and truncated to the lane width, with signed or unsigned lanes as `is_signed` selects.
- R3: Opcode 3'd1 (absolute difference) gives, per lane, a − b when a > b and b − a otherwise, truncated to the lane width; the comparison follows `is_signed`.
- R4: Opcode 3'd2 (accumulate) with `sat_en` = 0 gives, per lane, d + |a − b| wrapped modulo the lane width.
- R5: Opcode 3'd2 with `sat_en` = 1 clamps each lane sum to the lane maximum: 2^W − 1 for unsigned lanes, 2^(W−1) − 1 for signed lanes (d is read as signed when `is_signed` is 1).
- R6: Opcode 3'd3 (minimum) gives a when a < b else b; opcode 3'd4 (maximum) gives a when a > b else b; the comparison is signed or unsigned as `is_signed` selects.
- R7: `cond` is nonzero only for opcode 3'd3 or 3'd4 with `rc_en` = 1 and `elem_w` = 2'b11; it then describes b − a: bit 3 set when b − a is negative (a > b), bit 2 when positive (a < b), bit 1 when zero, bit 0 always 0. Otherwise `cond` is 4'b0000.
- R8: Opcodes 3'd5 to 3'd7 return `result` = 0 and `cond` = 0 with `illegal` = 1; legal opcodes return `illegal` = 0.
- R9: An operand is taken when `in_valid` and `in_ready` are both 1, and its result appears with `out_valid` = 1 on the next cycle; `in_ready` = 1 whenever no result is held or `out_ready` is 1; while `out_valid` = 1 and `out_ready` = 0 the outputs hold.
- R10: `elem_w` selects the lane width: 2'b00 = 8, 2'b01 = 16, 2'b10 = 32, 2'b11 = 64 bits; lane i occupies bits [i*W +: W] and lanes never exchange carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can take an operand |
| opcode | input | 3 | Operation select |
| elem_w | input | 2 | Lane width select |
| is_signed | input | 1 | Signed lanes when 1 |
| sat_en | input | 1 | Clamp accumulate when 1 |
| rc_en | input | 1 | Produce condition field for min/max |
| src_a | input | 64 | First source word |
| src_b | input | 64 | Second source word |
| src_d | input | 64 | Accumulator source word |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| result | output | 64 | Packed result |
| cond | output | 4 | Condition field |
| illegal | output | 1 | Opcode was not defined |

## Verification
The assertions watch the handshake on every cycle: a held result stays still under back-pressure, the unit refuses input while stalled, an accepted operand always produces a result, a drained stage empties, and the condition field never holds more than one flag and never accompanies an illegal opcode. The lane arithmetic itself (rounding, wrap versus clamp, signed versus unsigned comparisons and the per-width lane split) can only be shown by the bench scenarios, which compare every result against a lane-by-lane model across all widths and flag combinations.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int DATA_W = 64;
    localparam int COND_W = 4;

    typedef enum logic [2:0] {
        OP_AVG     = 3'd0,
        OP_ABSDIFF = 3'd1,
        OP_ABSACC  = 3'd2,
        OP_MIN     = 3'd3,
        OP_MAX     = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        EW_8  = 2'b00,
        EW_16 = 2'b01,
        EW_32 = 2'b10,
        EW_64 = 2'b11
    } ew_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

    function automatic logic op_is_legal(input logic [2:0] op);
        return op <= 3'd4;
    endfunction

endpackage

// File: rtl/pm_lane.sv
module pm_lane
    import pm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   op,
    input  logic         sgn,
    input  logic         sat,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] d,
    output logic [W-1:0] y,
    output logic         a_gt_b,
    output logic         a_lt_b,
    output logic         a_eq_b
);
    localparam int XW = W + 2;

    logic signed [XW-1:0] ax, bx, dx;
    logic signed [XW-1:0] avg_sum;
    logic signed [XW-1:0] diff;
    logic        [W-1:0]  mag;
    logic signed [XW-1:0] acc_sum;
    logic                 acc_over;
    logic        [W-1:0]  acc_val;
    logic        [W-1:0]  sat_max;

    always_comb begin
        ax = {{2{sgn & a[W-1]}}, a};
        bx = {{2{sgn & b[W-1]}}, b};
        dx = {{2{sgn & d[W-1]}}, d};
    end

    always_comb begin
        a_gt_b = ax > bx;
        a_lt_b = ax < bx;
        a_eq_b = (a == b);
    end

    always_comb begin
        avg_sum = ax + bx + XW'(1);
        diff    = a_gt_b ? (ax - bx) : (bx - ax);
        mag     = diff[W-1:0];
        acc_sum = dx + {2'b00, mag};
    end

    always_comb begin
        if (sgn) begin
            acc_over = ~acc_sum[XW-1] & (|acc_sum[W:W-1]);
            sat_max  = {1'b0, {(W-1){1'b1}}};
        end else begin
            acc_over = acc_sum[W];
            sat_max  = {W{1'b1}};
        end
        acc_val = (sat && acc_over) ? sat_max : acc_sum[W-1:0];
    end

    always_comb begin
        unique case (op)
            OP_AVG:     y = avg_sum[W:1];
            OP_ABSDIFF: y = mag;
            OP_ABSACC:  y = acc_val;
            OP_MIN:     y = a_lt_b ? a : b;
            OP_MAX:     y = a_gt_b ? a : b;
            default:    y = '0;
        endcase
    end

endmodule

// File: rtl/pm_slice.sv
module pm_slice
    import pm_pkg::*;
#(
    parameter int DW = 64,
    parameter int W  = 8
) (
    input  logic [2:0]    op,
    input  logic          sgn,
    input  logic          sat,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] y,
    output logic          gt0,
    output logic          lt0,
    output logic          eq0
);
    localparam int NL = DW / W;

    logic [NL-1:0] gt_v, lt_v, eq_v;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        pm_lane #(.W(W)) u_lane (
            .op     (op),
            .sgn    (sgn),
            .sat    (sat),
            .a      (a[i*W +: W]),
            .b      (b[i*W +: W]),
            .d      (d[i*W +: W]),
            .y      (y[i*W +: W]),
            .a_gt_b (gt_v[i]),
            .a_lt_b (lt_v[i]),
            .a_eq_b (eq_v[i])
        );
    end

    assign gt0 = gt_v[0];
    assign lt0 = lt_v[0];
    assign eq0 = eq_v[0];

endmodule

// File: rtl/pm_outstage.sv
module pm_outstage
    import pm_pkg::*;
#(
    parameter int DW = 64,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] d_res,
    input  logic [CW-1:0] d_cond,
    input  logic          d_ill,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] q_res,
    output logic [CW-1:0] q_cond,
    output logic          q_ill
);
    stage_e state, state_nx;
    logic   take;

    always_comb begin
        in_ready = (state == ST_EMPTY) || out_ready;
        take     = in_valid && in_ready;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (take) state_nx = ST_FULL;               // ACCEPT
            ST_FULL: begin
                if (out_ready && !take) state_nx = ST_EMPTY;      // DRAIN
                else                    state_nx = ST_FULL;       // REFILL / STALL
            end
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_res  <= '0;
            q_cond <= '0;
            q_ill  <= 1'b0;
        end else if (take) begin
            q_res  <= d_res;
            q_cond <= d_cond;
            q_ill  <= d_ill;
        end
    end

    assign out_valid = (state == ST_FULL);

endmodule

// File: rtl/pm_media_alu.sv
module pm_media_alu
    import pm_pkg::*;
#(
    parameter int DW = pm_pkg::DATA_W,
    parameter int CW = pm_pkg::COND_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [2:0]    opcode,
    input  logic [1:0]    elem_w,
    input  logic          is_signed,
    input  logic          sat_en,
    input  logic          rc_en,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] src_d,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] result,
    output logic [CW-1:0] cond,
    output logic          illegal
);
    localparam int NWID = 4;

    logic [DW-1:0] slice_y [NWID];
    logic [NWID-1:0] slice_gt, slice_lt, slice_eq;

    for (genvar k = 0; k < NWID; k++) begin : g_width
        pm_slice #(.DW(DW), .W(8 << k)) u_slice (
            .op  (opcode),
            .sgn (is_signed),
            .sat (sat_en),
            .a   (src_a),
            .b   (src_b),
            .d   (src_d),
            .y   (slice_y[k]),
            .gt0 (slice_gt[k]),
            .lt0 (slice_lt[k]),
            .eq0 (slice_eq[k])
        );
    end

    logic [DW-1:0] comb_res;
    logic [CW-1:0] comb_cond;
    logic          comb_ill;
    logic          want_cond;

    always_comb begin
        comb_ill  = !op_is_legal(opcode);
        comb_res  = comb_ill ? '0 : slice_y[elem_w];
        want_cond = rc_en && (elem_w == EW_64) &&
                    ((opcode == OP_MIN) || (opcode == OP_MAX));
        comb_cond = '0;
        if (want_cond)
            comb_cond = {slice_gt[NWID-1], slice_lt[NWID-1], slice_eq[NWID-1], 1'b0};
    end

    pm_outstage #(.DW(DW), .CW(CW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d_res     (comb_res),
        .d_cond    (comb_cond),
        .d_ill     (comb_ill),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q_res     (result),
        .q_cond    (cond),
        .q_ill     (illegal)
    );

endmodule

// File: rtl/pm_media_alu_chk.sv
module pm_media_alu_chk #(
    parameter int DW = 64,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] result,
    input logic [CW-1:0] cond,
    input logic          illegal
);
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(result) && $stable(cond) && $stable(illegal)); // R9
    AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R9
    AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R9
    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid); // R9
    AST_COND_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(cond) && !cond[0]); // R7
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && illegal |-> result == '0 && cond == '0); // R8
    AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R1
endmodule

bind pm_media_alu pm_media_alu_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result),
    .cond      (cond),
    .illegal   (illegal)
);

// File: tb/tb_pm_media_alu.sv
module tb_pm_media_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  opcode = '0;
    logic [1:0]  elem_w = '0;
    logic        is_signed = 1'b0;
    logic        sat_en = 1'b0;
    logic        rc_en = 1'b0;
    logic [63:0] src_a = '0, src_b = '0, src_d = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] result;
    logic [3:0]  cond;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit rand_ready = 1'b0;
    bit done = 1'b0;

    logic [68:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    pm_media_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .opcode(opcode), .elem_w(elem_w), .is_signed(is_signed), .sat_en(sat_en),
        .rc_en(rc_en), .src_a(src_a), .src_b(src_b), .src_d(src_d),
        .out_valid(out_valid), .out_ready(out_ready), .result(result),
        .cond(cond), .illegal(illegal)
    );

    task automatic check(input bit ok, input string tag, input logic [68:0] act, input logic [68:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string req_tag(input logic [2:0] op, input bit sat, input bit rc, input logic [1:0] ew);
        case (op)
            3'd0: return "R2/R10";
            3'd1: return "R3/R10";
            3'd2: return sat ? "R5/R10" : "R4/R10";
            3'd3, 3'd4: return (rc && ew == 2'b11) ? "R6/R7" : "R6/R10";
            default: return "R8";
        endcase
    endfunction

    function automatic logic signed [67:0] ext(input logic [63:0] v, input int w, input bit sg);
        logic signed [67:0] x;
        x = $signed({4'b0000, v});
        if (sg && v[w-1]) x = x - (68'sd1 <<< w);
        return x;
    endfunction

    function automatic logic [68:0] model(input logic [2:0] op, input logic [1:0] ew, input bit sg,
                                         input bit sat, input bit rc, input logic [63:0] a,
                                         input logic [63:0] b, input logic [63:0] d);
        int w;
        logic [63:0] m, res;
        logic [3:0]  cf;
        logic signed [67:0] ax, bx, dx, r, umax, smax;
        w = 8 << ew;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        umax = (68'sd1 <<< w) - 68'sd1;
        smax = (68'sd1 <<< (w - 1)) - 68'sd1;
        res = '0;
        cf = '0;
        if (op > 3'd4) return {64'd0, 4'd0, 1'b1};
        for (int i = 0; i < 64 / w; i++) begin
            ax = ext((a >> (i * w)) & m, w, sg);
            bx = ext((b >> (i * w)) & m, w, sg);
            dx = ext((d >> (i * w)) & m, w, sg);
            case (op)
                3'd0: r = (ax + bx + 68'sd1) >>> 1;
                3'd1: r = (ax > bx) ? ax - bx : bx - ax;
                3'd2: begin
                    r = dx + ((ax > bx) ? ax - bx : bx - ax);
                    if (sat && sg && r > smax) r = smax;
                    if (sat && !sg && r > umax) r = umax;
                end
                3'd3: r = (ax < bx) ? ax : bx;
                default: r = (ax > bx) ? ax : bx;
            endcase
            res = res | ((r[63:0] & m) << (i * w));
            if (w == 64 && rc && (op == 3'd3 || op == 3'd4))
                cf = {ax > bx, ax < bx, ax == bx, 1'b0};
        end
        return {res, cf, 1'b0};
    endfunction

    task automatic send(input logic [2:0] op, input logic [1:0] ew, input bit sg, input bit sat,
                        input bit rc, input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
        @(negedge clk);
        opcode = op; elem_w = ew; is_signed = sg; sat_en = sat; rc_en = rc;
        src_a = a; src_b = b; src_d = d; in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(op, ew, sg, sat, rc, a, b, d));
        tag_q.push_back(req_tag(op, sat, rc, ew));
        @(posedge clk);
    endtask

    // consumer: back-pressure pattern changes just after each rising edge
    always @(posedge clk) begin
        #1;
        if (rand_ready) out_ready = ($urandom % 4) != 0;
        else            out_ready = 1'b1;
    end

    // monitor: checks held data under stall (R9) and pops the scoreboard
    initial begin
        bit          pend = 1'b0;
        logic [63:0] held = '0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (pend) begin
                    check(out_valid && result == held, "R9 hold", {result, 5'd0}, {held, 5'd0});
                    pend = 1'b0;
                end
                if (out_valid && !out_ready) begin
                    check(!in_ready, "R9 ready-low", {68'd0, in_ready}, 69'd0);
                    pend = 1'b1;
                    held = result;
                end
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 spurious", {result, cond, illegal}, 69'd0);
                    end else begin
                        logic [68:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({result, cond, illegal} == e, t, {result, cond, illegal}, e);
                    end
                end
            end
        end
    end

    initial begin
        #1000000;
        check(1'b0, "watchdog", 69'd0, 69'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && in_ready, "R1 reset", {67'd0, out_valid, in_ready}, 69'd1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid && in_ready, "R1 after reset", {67'd0, out_valid, in_ready}, 69'd1);

        // directed corners
        send(3'd0, 2'b00, 0, 0, 0, 64'hFFFF_0100_FF01_0000, 64'hFFFE_0300_0001_0001, 0); // R2 unsigned rounding
        send(3'd0, 2'b00, 1, 0, 0, 64'h7F80_8080_7F7F_FF01, 64'h7F80_7F81_0180_01FF, 0); // R2 signed
        send(3'd0, 2'b11, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0); // R2 64-bit carry
        send(3'd1, 2'b01, 1, 0, 0, 64'h8000_7FFF_0005_FFFF, 64'h7FFF_8000_0009_0001, 0); // R3 signed extremes
        send(3'd1, 2'b10, 0, 0, 0, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 0); // R3 unsigned
        send(3'd2, 2'b00, 0, 0, 0, 64'h00FF_0000_0000_00F0, 64'h0000_00FF_0000_0010, 64'h01FF_FFFF_0000_FF50); // R4 wrap
        send(3'd2, 2'b00, 0, 1, 0, 64'h00FF_0000_0000_00F0, 64'h0000_00FF_0000_0010, 64'h01FF_FFFF_0000_FF50); // R5 unsigned clamp
        send(3'd2, 2'b01, 1, 1, 0, 64'h8000_7FFF_0001_0000, 64'h7FFF_8000_0000_0000, 64'h7FF0_8000_7FFF_0001); // R5 signed clamp
        send(3'd2, 2'b11, 1, 0, 0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF); // R4 64-bit wrap
        send(3'd3, 2'b00, 1, 0, 0, 64'h80_7F_00_FF_01_02_03_04, 64'h7F_80_FF_00_01_01_04_03, 0); // R6 signed min
        send(3'd4, 2'b00, 0, 0, 0, 64'h80_7F_00_FF_01_02_03_04, 64'h7F_80_FF_00_01_01_04_03, 0); // R6 unsigned max
        send(3'd3, 2'b11, 1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);  // R7 a<b signed
        send(3'd4, 2'b11, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);  // R7 a>b unsigned
        send(3'd4, 2'b11, 0, 0, 1, 64'h1234, 64'h1234, 0);              // R7 equal
        send(3'd3, 2'b10, 0, 0, 1, 64'h1, 64'h2, 0);                    // R7 no cond below 64
        send(3'd1, 2'b11, 0, 0, 1, 64'h1, 64'h2, 0);                    // R7 no cond for absdiff
        send(3'd5, 2'b00, 0, 0, 1, 64'h1, 64'h2, 64'h3);                // R8
        send(3'd7, 2'b11, 1, 1, 1, 64'hF, 64'h2, 64'h3);                // R8

        // randomized mix under back-pressure: R2..R10
        rand_ready = 1'b1;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b, d;
            a = {$urandom, $urandom};
            b = (i % 5 == 0) ? a : {$urandom, $urandom};
            d = {$urandom, $urandom};
            send(3'($urandom % 8), 2'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom), a, b, d);
            if (i % 7 == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (2) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        rand_ready = 1'b0;
        for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && !out_valid, "R9 drained", {37'd0, 32'(exp_q.size())}, 69'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule